// File: doc/BRIEF.md
# Periodic Clock Trim Unit

This block trims a real-time clock whose seconds come from a prescaler that divides a slow oscillator. Once in every adjustment interval it lengthens or shortens a single second by a programmed whole number of oscillator cycles. The interval is either a short one (10 seconds by default) or a long one (60 seconds by default). Each cycle of correction is worth 1/(f·10) of time in the short interval and 1/(f·60) in the long one, where f is the oscillator frequency. This gives software two step sizes for cancelling a crystal's frequency error.

Two byte-wide registers hold the setting. The trim register holds a 6-bit cycle count and a 2-bit direction code. The control register holds the automatic-trim enable and the interval select. The block contains the prescaler counter and the seconds-within-interval counter. It emits a one-cycle tick at the end of every second, along with the trim command that applies to the second now being counted. The interval select cannot be changed while a direction is programmed, so the step size cannot change under an active correction.

Top module: `rtc_trim`

## Requirements
- R1: After reset both registers read 0x00, `adj_active` is low and no trim is applied.
- R2: With no trim in force, every second lasts exactly DIV clock cycles from one `sec_tick` to the next.
- R3: The trim register (address 0) holds the cycle count N in bits 5:0 and the direction code in bits 7:6, and reads back the last byte written. The control register (address 1) holds the enable in bit 0 and the interval select in bit 1 (1 = short interval), and reads 0 in bits 7:2.
- R4: Direction code 1 (add) makes the trimmed second last DIV−N cycles, for every N from 0 to 63.
- R5: Direction code 2 (subtract) makes the trimmed second last DIV+N cycles, for every N from 0 to 63.
- R6: Direction codes 0 and 3 apply no trim. Every second lasts DIV cycles and `adj_active` stays low.
- R7: While the enable bit is clear, no trim is applied, whatever the trim register holds.
- R8: Exactly one second in every SHORT_SECS seconds is trimmed when the interval select is 1. Exactly one in every LONG_SECS seconds is trimmed when it is 0.
- R9: A control write while the direction code is nonzero leaves the interval select unchanged but still updates the enable. With the direction code zero, the interval select takes the written value.
- R10: The trim setting is sampled when a second begins. Throughout a trimmed second, `adj_active` is high, `adj_add` is 1 for add and 0 for subtract, and `adj_cycles` equals N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 trim, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 trim, 1 control |
| rd_data | output | 8 | Read data of the addressed register |
| sec_tick | output | 1 | High in the last cycle of each second |
| adj_active | output | 1 | The current second is trimmed |
| adj_add | output | 1 | Trim shortens (1) or lengthens (0) the second |
| adj_cycles | output | 6 | Trim amount of the current second |

## Verification
The bench builds the block with DIV = 100, SHORT_SECS = 3 and LONG_SECS = 5. This makes a second 100 cycles long and an interval a few hundred cycles long. Full intervals can then be recorded in both modes, including the largest trims of ±63 cycles. The bench sweeps the cycle count across its range in both directions, and it also covers the two no-trim codes, a cleared enable, and the blocked and allowed interval changes. For each case it derives the expected second lengths and trim positions arithmetically.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
   localparam int TRIM_CW = 6;
   localparam int REG_W   = 8;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_ADD  = 2'd1,
      DIR_SUB  = 2'd2,
      DIR_RSVD = 2'd3
   } trim_dir_e;

   typedef struct packed {
      logic               active;
      logic               add;
      logic [TRIM_CW-1:0] cyc;
   } trim_cmd_t;
endpackage

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
   import rtc_trim_pkg::*;
#(
   parameter int CW = TRIM_CW,
   parameter int RW = REG_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          wr_addr,
   input  logic [RW-1:0] wr_data,
   input  logic          rd_addr,
   output logic [RW-1:0] rd_data,
   output logic [CW-1:0] trim_cyc,
   output trim_dir_e     trim_dir,
   output logic          auto_en,
   output logic          short_ivl
);
   localparam int CTRL_PAD = RW - 2;

   generate
      if (RW != CW + 2) begin : g_bad_w
         $error("register width must be cycle width plus two direction bits");
      end
   endgenerate

   logic [RW-1:0] trim_q;
   logic          en_q;
   logic          short_q;
   logic          dir_busy;

   assign dir_busy = (trim_q[RW-1:CW] != 2'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trim_q  <= '0;
         en_q    <= 1'b0;
         short_q <= 1'b0;
      end else if (wr_en) begin
         if (!wr_addr) begin
            trim_q <= wr_data;
         end else begin
            en_q <= wr_data[0];
            if (!dir_busy) short_q <= wr_data[1];
         end
      end
   end

   assign rd_data   = rd_addr ? {{CTRL_PAD{1'b0}}, short_q, en_q} : trim_q;
   assign trim_cyc  = trim_q[CW-1:0];
   assign trim_dir  = trim_dir_e'(trim_q[RW-1:CW]);
   assign auto_en   = en_q;
   assign short_ivl = short_q;

   AST_IVL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr && dir_busy) |=> $stable(short_q)); // R9
   AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr) |=> (en_q == $past(wr_data[0]))); // R9
endmodule

// File: rtl/rtc_trim_interval.sv
module rtc_trim_interval #(
   parameter int SHORT_SECS = 10,
   parameter int LONG_SECS  = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_tick,
   input  logic short_ivl,
   output logic wrap_tick
);
   localparam int MAXS = (LONG_SECS > SHORT_SECS) ? LONG_SECS : SHORT_SECS;
   localparam int IW   = $clog2(MAXS + 1);
   localparam logic [IW-1:0] SHORT_LAST = IW'(SHORT_SECS - 1);
   localparam logic [IW-1:0] LONG_LAST  = IW'(LONG_SECS - 1);

   generate
      if (SHORT_SECS < 1 || LONG_SECS < 1) begin : g_bad_len
         $error("interval lengths must be at least one second");
      end
   endgenerate

   logic [IW-1:0] idx_q;
   logic [IW-1:0] last;

   assign last      = short_ivl ? SHORT_LAST : LONG_LAST;
   assign wrap_tick = sec_tick && (idx_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         idx_q <= '0;
      else if (wrap_tick) idx_q <= '0;
      else if (sec_tick)  idx_q <= idx_q + 1'b1;
   end

   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q < IW'(MAXS)); // R8
   AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_tick |=> (idx_q == '0)); // R8
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
   import rtc_trim_pkg::*;
#(
   parameter int DIV = 32768,
   parameter int CW  = TRIM_CW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wrap_tick,
   input  logic          auto_en,
   input  trim_dir_e     trim_dir,
   input  logic [CW-1:0] trim_cyc,
   output logic          sec_tick,
   output trim_cmd_t     cmd
);
   localparam int MAXADJ = (1 << CW) - 1;
   localparam int PW     = $clog2(DIV + MAXADJ + 1);
   localparam logic [PW-1:0] NOM_TC = PW'(DIV - 1);

   generate
      if (DIV <= MAXADJ + 1) begin : g_bad_div
         $error("prescaler divide must exceed the largest trim");
      end
   endgenerate

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] tc;
   trim_cmd_t     cmd_q;
   logic          take;

   always_comb begin
      tc = NOM_TC;
      if (cmd_q.active) begin
         if (cmd_q.add) tc = NOM_TC - PW'(cmd_q.cyc);
         else           tc = NOM_TC + PW'(cmd_q.cyc);
      end
   end

   assign sec_tick = (cnt_q == tc);
   assign take     = wrap_tick && auto_en &&
                     (trim_dir == DIR_ADD || trim_dir == DIR_SUB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cmd_q <= '0;
      end else if (sec_tick) begin
         cnt_q        <= '0;
         cmd_q.active <= take;
         cmd_q.add    <= (trim_dir == DIR_ADD);
         cmd_q.cyc    <= trim_cyc;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cmd = cmd_q;

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= tc); // R2
   AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> (cnt_q == '0)); // R2
   AST_CMD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_q.active) |-> $past(wrap_tick)); // R8
   AST_CMD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_q.active) |-> $past(auto_en)); // R7
   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sec_tick)) |-> $stable(cmd_q)); // R10
endmodule

// File: rtl/rtc_trim.sv
module rtc_trim
   import rtc_trim_pkg::*;
#(
   parameter int DIV        = 32768,
   parameter int SHORT_SECS = 10,
   parameter int LONG_SECS  = 60
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_addr,
   input  logic [REG_W-1:0]   wr_data,
   input  logic               rd_addr,
   output logic [REG_W-1:0]   rd_data,
   output logic               sec_tick,
   output logic               adj_active,
   output logic               adj_add,
   output logic [TRIM_CW-1:0] adj_cycles
);
   logic [TRIM_CW-1:0] trim_cyc;
   trim_dir_e          trim_dir;
   logic               auto_en;
   logic               short_ivl;
   logic               wrap_tick;
   trim_cmd_t          cmd;

   rtc_trim_regs #(.CW(TRIM_CW), .RW(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .trim_cyc(trim_cyc), .trim_dir(trim_dir), .auto_en(auto_en),
      .short_ivl(short_ivl)
   );

   rtc_trim_interval #(.SHORT_SECS(SHORT_SECS), .LONG_SECS(LONG_SECS)) u_ivl (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .short_ivl(short_ivl),
      .wrap_tick(wrap_tick)
   );

   rtc_trim_prescaler #(.DIV(DIV), .CW(TRIM_CW)) u_presc (
      .clk(clk), .rst_n(rst_n), .wrap_tick(wrap_tick), .auto_en(auto_en),
      .trim_dir(trim_dir), .trim_cyc(trim_cyc), .sec_tick(sec_tick),
      .cmd(cmd)
   );

   assign adj_active = cmd.active;
   assign adj_add    = cmd.add;
   assign adj_cycles = cmd.cyc;
endmodule

// File: tb/rtc_trim_tb.sv
module rtc_trim_tb;
   localparam int DIV = 100;
   localparam int SS  = 3;
   localparam int LS  = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_addr = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_addr = 1'b0;
   logic [7:0] rd_data;
   logic       sec_tick, adj_active, adj_add;
   logic [5:0] adj_cycles;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int lens [0:31];
   bit actv [0:31];
   bit addv [0:31];
   int cycv [0:31];

   always #10 clk = ~clk;

   rtc_trim #(.DIV(DIV), .SHORT_SECS(SS), .LONG_SECS(LS)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .sec_tick(sec_tick), .adj_active(adj_active), .adj_add(adj_add),
      .adj_cycles(adj_cycles)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input bit a, output logic [7:0] d);
      rd_addr = a;
      @(negedge clk);
      d = rd_data;
   endtask

   task automatic rec(input int n);
      int c;
      @(negedge clk);
      while (!sec_tick) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         c = 0;
         do begin
            @(negedge clk);
            c++;
         end while (!sec_tick);
         lens[i] = c;
         actv[i] = adj_active;
         addv[i] = adj_add;
         cycv[i] = int'(adj_cycles);
      end
   endtask

   task automatic check_pattern(input string req, input int l, input bit en,
                                input int dir, input int n);
      bit exp_adj;
      int first, explen, n_rec, bad_j, bad_act, bad_exp;
      bit ok, isadj;
      exp_adj = en && (dir == 1 || dir == 2);
      explen  = (dir == 1) ? DIV - n : DIV + n;
      n_rec   = 3 * l;
      first   = -1;
      for (int j = 0; j < l; j++) if (actv[j] && first < 0) first = j;
      ok = 1; bad_j = -1; bad_act = 0; bad_exp = 0;
      if (exp_adj && first < 0) begin
         ok = 0; bad_act = -1; bad_exp = 0;
      end else begin
         for (int j = 0; j < n_rec; j++) begin
            isadj = exp_adj && ((j % l) == first);
            if (ok && (actv[j] != isadj || lens[j] != (isadj ? explen : DIV) ||
                       (isadj && (addv[j] != (dir == 1) || cycv[j] != n)))) begin
               ok = 0; bad_j = j;
               bad_act = lens[j]; bad_exp = isadj ? explen : DIV;
            end
         end
      end
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: dir %0d n %0d second %0d length/marker actual %0d expected %0d",
                  req, dir, n, bad_j, bad_act, bad_exp);
      end
   endtask

   task automatic run_case(input string req, input bit sh, input bit en,
                           input int dir, input int n);
      int l;
      l = sh ? SS : LS;
      wr(1'b0, 8'h00);
      wr(1'b1, {6'd0, sh, en});
      wr(1'b0, {2'(dir), 6'(n)});
      rec(l + 1);
      rec(3 * l);
      check_pattern(req, l, en, dir, n);
   endtask

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rd(1'b0, d); chk("R1 trim reg reset", d, 0);
      rd(1'b1, d); chk("R1 ctrl reg reset", d, 0);
      chk("R1 adj_active reset", adj_active, 0);
      rst_n = 1'b1;

      // R2: nominal seconds right after reset
      rec(6);
      for (int j = 0; j < 6; j++) chk("R2 nominal second", lens[j], DIV);

      // R3 / R9: readback and interval lock
      wr(1'b0, 8'hC5); rd(1'b0, d); chk("R3 trim readback", d, 8'hC5);
      wr(1'b1, 8'hFF); rd(1'b1, d); chk("R9 interval held, enable set", d, 8'h01);
      wr(1'b0, 8'h00); wr(1'b1, 8'hFE); rd(1'b1, d);
      chk("R3 ctrl readback upper bits zero", d, 8'h02);
      wr(1'b0, 8'h7F); rd(1'b0, d); chk("R3 trim readback add 63", d, 8'h7F);

      // R4 / R5 / R8 / R10: sweep over N in short mode
      for (int n = 0; n < 64; n += 9) begin
         run_case("R4 R8 R10 add short", 1'b1, 1'b1, 1, n);
         run_case("R5 R8 R10 sub short", 1'b1, 1'b1, 2, n);
      end
      run_case("R4 R8 add long max", 1'b0, 1'b1, 1, 63);
      run_case("R5 R8 sub long", 1'b0, 1'b1, 2, 5);
      run_case("R5 sub long max", 1'b0, 1'b1, 2, 63);
      run_case("R6 code 3", 1'b1, 1'b1, 3, 20);
      run_case("R6 code 0", 1'b1, 1'b1, 0, 20);
      run_case("R7 disabled", 1'b1, 1'b0, 1, 30);
      run_case("R7 disabled sub", 1'b0, 1'b0, 2, 40);

      // R9: blocked interval change keeps short period
      run_case("R9 setup short", 1'b1, 1'b1, 1, 10);
      wr(1'b1, 8'h01); rd(1'b1, d); chk("R9 interval write ignored", d, 8'h03);
      rec(SS + 1); rec(3 * SS);
      check_pattern("R9 period unchanged", SS, 1'b1, 1, 10);
      wr(1'b0, 8'h00); wr(1'b1, 8'h01); rd(1'b1, d);
      chk("R9 interval write accepted", d, 8'h01);
      wr(1'b0, 8'h4A);
      rec(LS + 1); rec(3 * LS);
      check_pattern("R9 R8 long period after change", LS, 1'b1, 1, 10);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule